// File: doc/BRIEF.md
# Command-Encoded Control Byte Register

This block is the byte-wide write side of a memory-controller control register. Each byte written is read as a small command. The middle four bits carry an operation code. A nonzero operation code changes exactly one internal control parameter: the instruction page-cache enable, the data page-cache enable, or the timer interrupt output mode. It can instead raise a one-cycle timer acknowledge.

While a nonzero code is present, the two outer fields of the byte are masked automatically. These are a reserved test pair in bits 1:0 and the low refresh-rate pair in bits 7:6. Software can therefore set one parameter with a single byte store and does not need to read the register back first. An all-zero code is the only way to load the two outer fields.

The timer and the refresh generator that use these outputs sit outside the block. Reset clears every control function. The asynchronous reset input is released to the logic through a short synchronizer.

Top module: `ctl_byte_reg`

## Requirements
- R1: When wr_en is high and bits 5:2 of wr_data are nonzero, test_bits and refresh_lo keep their previous values.
- R2: When wr_en is high and bits 5:2 of wr_data are 0000, test_bits takes wr_data[1:0] and refresh_lo takes wr_data[7:6] after the clock edge. The page-cache enables and tmr_mode do not change.
- R3: Code 0110 in bits 5:2 sets icache_en to 1, and code 0100 clears it to 0.
- R4: Code 0111 in bits 5:2 sets dcache_en to 1, and code 0101 clears it to 0.
- R5: tmr_mode is encoded as 00 = interrupts disabled, 01 = level sense, 10 = edge sense. Code 1010 selects level sense, code 1110 selects edge sense, and code 1100 disables the timer interrupts.
- R6: tmr_ack is high only during a cycle in which wr_en is high and bits 5:2 equal 1000. That code changes no stored state.
- R7: Codes 0001, 0010, 0011, 1001, 1011, 1101 and 1111 change no output.
- R8: While rst_n is low, every output is 0 (both caches off, tmr_mode 00, tmr_ack 0, test_bits 00, refresh_lo 00). Release of reset reaches the logic after SYNC_STAGES clock edges.
- R9: While wr_en is low, no output changes and tmr_ack stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Written byte: [7:6] refresh, [5:2] operation code, [1:0] test |
| icache_en | output | 1 | Instruction page-cache enable |
| dcache_en | output | 1 | Data page-cache enable |
| tmr_mode | output | 2 | Timer interrupt output mode (00 off, 01 level, 10 edge) |
| tmr_ack | output | 1 | Timer interrupt acknowledge pulse |
| test_bits | output | 2 | Reserved test field |
| refresh_lo | output | 2 | Low refresh-rate bits |

## Verification
Several properties are checked on every cycle by assertions:
- at most one decoded action is active;
- the outer fields hold under a nonzero code and load under a zero code;
- the flags follow their set and clear actions and stay stable when no action is decoded;
- tmr_ack is high only during a write that carries the acknowledge code.

The bench's scenarios are needed for other behaviour:
- the exact values after sequences of writes;
- the inertness of every unlisted code as seen at all outputs;
- the all-zero state during reset, including a reset applied in the middle of a run;
- the independence of the two cache flags from each other.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int TEST_W   = 2;
  localparam int CMD_W    = 4;
  localparam int RATE_W   = 2;
  localparam int DATA_W   = TEST_W + CMD_W + RATE_W;
  localparam int TEST_LSB = 0;
  localparam int CMD_LSB  = TEST_LSB + TEST_W;
  localparam int RATE_LSB = CMD_LSB + CMD_W;

  localparam logic [CMD_W-1:0] OP_LOAD     = 4'b0000;
  localparam logic [CMD_W-1:0] OP_IC_OFF   = 4'b0100;
  localparam logic [CMD_W-1:0] OP_IC_ON    = 4'b0110;
  localparam logic [CMD_W-1:0] OP_DC_OFF   = 4'b0101;
  localparam logic [CMD_W-1:0] OP_DC_ON    = 4'b0111;
  localparam logic [CMD_W-1:0] OP_TMR_ACK  = 4'b1000;
  localparam logic [CMD_W-1:0] OP_TMR_LVL  = 4'b1010;
  localparam logic [CMD_W-1:0] OP_TMR_OFF  = 4'b1100;
  localparam logic [CMD_W-1:0] OP_TMR_EDGE = 4'b1110;

  typedef enum logic [1:0] {
    TMR_OFF   = 2'b00,
    TMR_LEVEL = 2'b01,
    TMR_EDGE  = 2'b10
  } tmr_mode_e;

  typedef struct packed {
    logic load_fields;
    logic ic_on;
    logic ic_off;
    logic dc_on;
    logic dc_off;
    logic tmr_ack;
    logic tmr_lvl;
    logic tmr_edge;
    logic tmr_off;
  } ctl_act_t;
endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
  import ctl_pkg::*;
(
  input  logic             wr_en,
  input  logic [CMD_W-1:0] cmd,
  output ctl_act_t         act
);
  always_comb begin
    act = '0;
    if (wr_en) begin
      case (cmd)
        OP_LOAD:     act.load_fields = 1'b1;
        OP_IC_ON:    act.ic_on       = 1'b1;
        OP_IC_OFF:   act.ic_off      = 1'b1;
        OP_DC_ON:    act.dc_on       = 1'b1;
        OP_DC_OFF:   act.dc_off      = 1'b1;
        OP_TMR_ACK:  act.tmr_ack     = 1'b1;
        OP_TMR_LVL:  act.tmr_lvl     = 1'b1;
        OP_TMR_EDGE: act.tmr_edge    = 1'b1;
        OP_TMR_OFF:  act.tmr_off     = 1'b1;
        default:     act = '0;
      endcase
    end
  end
endmodule

// File: rtl/ctl_flag_bank.sv
module ctl_flag_bank
  import ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctl_act_t  act,
  output logic      ic_q,
  output logic      dc_q,
  output tmr_mode_e mode_q
);
  logic      ic_d, dc_d, ic_en, dc_en, mode_en;
  tmr_mode_e mode_d;

  always_comb begin
    ic_en   = act.ic_on | act.ic_off;
    dc_en   = act.dc_on | act.dc_off;
    mode_en = act.tmr_lvl | act.tmr_edge | act.tmr_off;
    ic_d    = act.ic_on;
    dc_d    = act.dc_on;
    if (act.tmr_lvl)       mode_d = TMR_LEVEL;
    else if (act.tmr_edge) mode_d = TMR_EDGE;
    else                   mode_d = TMR_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_q   <= 1'b0;
      dc_q   <= 1'b0;
      mode_q <= TMR_OFF;
    end else begin
      if (ic_en)   ic_q   <= ic_d;
      if (dc_en)   dc_q   <= dc_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  // R7
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));
  // R3
  ic_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.ic_on |=> ic_q);
  // R3
  ic_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.ic_off |=> !ic_q);
  // R4
  dc_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.dc_on |=> dc_q);
  // R5
  tmr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act.tmr_edge |=> mode_q == TMR_EDGE);
  // R9
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ic_en | dc_en | mode_en) |=> $stable(ic_q) && $stable(dc_q) && $stable(mode_q));
endmodule

// File: rtl/ctl_field_store.sv
module ctl_field_store
  import ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              masked,
  input  logic [TEST_W-1:0] test_in,
  input  logic [RATE_W-1:0] rate_in,
  output logic [TEST_W-1:0] test_q,
  output logic [RATE_W-1:0] rate_q
);
  logic [TEST_W-1:0] test_d;
  logic [RATE_W-1:0] rate_d;

  always_comb begin
    test_d = load ? test_in : test_q;
    rate_d = load ? rate_in : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q <= '0;
      rate_q <= '0;
    end else if (load) begin
      test_q <= test_d;
      rate_q <= rate_d;
    end
  end

  // R1
  fields_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    masked |=> $stable(test_q) && $stable(rate_q));
  // R2
  fields_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> test_q == $past(test_in) && rate_q == $past(rate_in));
endmodule

// File: rtl/ctl_byte_reg.sv
module ctl_byte_reg
  import ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              icache_en,
  output logic              dcache_en,
  output logic [1:0]        tmr_mode,
  output logic              tmr_ack,
  output logic [TEST_W-1:0] test_bits,
  output logic [RATE_W-1:0] refresh_lo
);
  logic             rst_q_n;
  logic [CMD_W-1:0] cmd;
  ctl_act_t         act;
  tmr_mode_e        mode_q;
  logic             masked;

  assign cmd    = wr_data[CMD_LSB +: CMD_W];
  assign masked = wr_en & (|cmd);

  ctl_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  ctl_cmd_decode u_dec (.wr_en(wr_en), .cmd(cmd), .act(act));

  ctl_flag_bank u_flags (
    .clk(clk), .rst_n(rst_q_n), .act(act),
    .ic_q(icache_en), .dc_q(dcache_en), .mode_q(mode_q));

  ctl_field_store u_fields (
    .clk(clk), .rst_n(rst_q_n), .load(act.load_fields), .masked(masked),
    .test_in(wr_data[TEST_LSB +: TEST_W]), .rate_in(wr_data[RATE_LSB +: RATE_W]),
    .test_q(test_bits), .rate_q(refresh_lo));

  assign tmr_mode = mode_q;
  assign tmr_ack  = act.tmr_ack & rst_q_n;

  // R6
  ack_source_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    tmr_ack |-> wr_en && wr_data[CMD_LSB +: CMD_W] == OP_TMR_ACK);
  // R6
  ack_no_state_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    tmr_ack |=> $stable(icache_en) && $stable(dcache_en) && $stable(tmr_mode)
                && $stable(test_bits) && $stable(refresh_lo));
endmodule

// File: tb/tb_ctl_byte_reg.sv
`timescale 1ns/1ps
module tb_ctl_byte_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       icache_en, dcache_en, tmr_ack;
  logic [1:0] tmr_mode, test_bits, refresh_lo;

  int checks = 0;
  int errors = 0;
  logic       m_ic, m_dc;
  logic [1:0] m_mode, m_test, m_rate;

  always #4 clk = ~clk;

  ctl_byte_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .icache_en(icache_en), .dcache_en(dcache_en), .tmr_mode(tmr_mode),
    .tmr_ack(tmr_ack), .test_bits(test_bits), .refresh_lo(refresh_lo));

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] outs();
    return {tmr_ack, refresh_lo, test_bits, tmr_mode, dcache_en, icache_en};
  endfunction

  function automatic logic [8:0] model();
    return {1'b0, m_rate, m_test, m_mode, m_dc, m_ic};
  endfunction

  task automatic apply(input logic [7:0] d);
    case (d[5:2])
      4'b0000: begin m_test = d[1:0]; m_rate = d[7:6]; end
      4'b0110: m_ic = 1'b1;
      4'b0100: m_ic = 1'b0;
      4'b0111: m_dc = 1'b1;
      4'b0101: m_dc = 1'b0;
      4'b1010: m_mode = 2'b01;
      4'b1110: m_mode = 2'b10;
      4'b1100: m_mode = 2'b00;
      default: ;
    endcase
  endtask

  task automatic wr(input string req, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    #1 chk({req, " ack"}, {8'h0, tmr_ack}, {8'h0, d[5:2] == 4'b1000});
    apply(d);
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d;
    #1 chk(req, outs(), model());
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    m_ic = 0; m_dc = 0; m_mode = 0; m_test = 0; m_rate = 0;
    repeat (2) @(negedge clk);
    chk("R8 reset state", outs(), 9'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 after release", outs(), 9'h0);
  endtask

  task automatic t_load();
    wr("R2 load C3", 8'hC3);
    wr("R2 load 42", 8'h42);
    wr("R2 load 81", 8'h81);
  endtask

  task automatic t_masked();
    wr("R2 preload", 8'hC3);
    wr("R1 masked ic on", 8'h18);
    wr("R1 masked ack", 8'h20);
    wr("R1 masked 3C", 8'h3C);
  endtask

  task automatic t_icache();
    wr("R3 ic on", 8'h18);
    wr("R3 ic on again", 8'hD8);
    wr("R3 ic off", 8'h10);
  endtask

  task automatic t_dcache();
    wr("R4 dc on", 8'h1C);
    wr("R3 ic on beside dc", 8'h18);
    wr("R4 dc off", 8'h14);
    wr("R3 ic off", 8'h10);
  endtask

  task automatic t_timer();
    wr("R5 level", 8'h28);
    wr("R5 edge", 8'h38);
    wr("R6 ack keeps mode", 8'h20);
    wr("R5 off", 8'h30);
  endtask

  task automatic t_unlisted();
    wr("R2 preload", 8'h82);
    wr("R3 ic on", 8'h18);
    wr("R5 edge", 8'h38);
    wr("R7 code 0001", 8'h04);
    wr("R7 code 0010", 8'h4B);
    wr("R7 code 0011", 8'hCC);
    wr("R7 code 1001", 8'h24);
    wr("R7 code 1011", 8'h2C);
    wr("R7 code 1101", 8'h34);
    wr("R7 code 1111", 8'hFF);
  endtask

  task automatic t_idle();
    @(negedge clk);
    wr_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      wr_data = 8'h00 + 8'(i * 4);
      @(negedge clk);
      #1 chk("R9 idle", outs(), model());
    end
  endtask

  task automatic t_midrun_reset();
    wr("R4 dc on", 8'h1C);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    m_ic = 0; m_dc = 0; m_mode = 0; m_test = 0; m_rate = 0;
    chk("R8 async clear", outs(), 9'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 cleared after release", outs(), 9'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load();
        t_masked();
        t_icache();
        t_dcache();
        t_timer();
        t_unlisted();
        t_idle();
        t_midrun_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule